// File: doc/BRIEF.md
# Register Stack with Postfix Arithmetic

A last-in, first-out stack of registers with a parameterised number of entries and word width. Its stack pointer starts at the bottom value, equal to the depth, and moves down toward zero as words are pushed. FULL and EMPTY flags are held in registers and are updated from the new pointer value whenever a command changes it. One command is accepted on each clock. The available commands are push (with a data word), pop (which returns the top word), and the two zero-address operations add and multiply. Each of these operations takes the two top entries, combines them, and leaves one result in their place, so a postfix expression can be evaluated one token at a time.

A command that cannot be carried out at the current occupancy leaves all state unchanged and raises a one-cycle error pulse. This covers a push to a full stack, a pop from an empty stack, an operation with fewer than two entries, and an unknown code. The top entry is always visible on an output. A popped word appears on a held data output, marked by a one-cycle valid pulse.

Top module: `rpn_stack`

## Requirements
- R1: While reset is asserted and after it is released, the pointer equals DEPTH, EMPTY is 1, FULL is 0, and the error and pop-valid outputs are 0.
- R2: A push (cmd code 1) when not full first decrements the pointer and then writes the data word at the new pointer. On the next cycle the top output shows that word.
- R3: FULL becomes 1 after a push leaves the pointer at 0. Any accepted push clears EMPTY. FULL and EMPTY are never both 1.
- R4: A pop (cmd code 2) when not empty returns the word at the pointer on the data output, pulses pop-valid for one cycle, and then increments the pointer. Words come back in reverse order of pushing.
- R5: EMPTY becomes 1 after a pop returns the pointer to DEPTH. Any accepted pop clears FULL.
- R6: Add (cmd code 3) with two or more entries replaces the two top entries with their sum, truncated to WIDTH bits. The pointer rises by one.
- R7: Multiply (cmd code 4) with two or more entries replaces the two top entries with the low WIDTH bits of their product. The pointer rises by one.
- R8: A push while FULL leaves the pointer and the contents unchanged and gives a one-cycle error pulse.
- R9: A pop while EMPTY leaves the state unchanged, gives a one-cycle error pulse, and keeps pop-valid at 0.
- R10: Add or multiply with fewer than two entries leaves the pointer and the top entry unchanged and gives a one-cycle error pulse.
- R11: Code 0 is a no-operation with no error. Codes 5 to 7 are ignored and give a one-cycle error pulse.
- R12: The postfix sequence push 3, push 4, multiply, push 5, push 6, multiply, add leaves exactly one entry, with value 42.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Command code: 0 nop, 1 push, 2 pop, 3 add, 4 multiply |
| data_i | input | WIDTH | Word to push |
| data_o | output | WIDTH | Last popped word (held) |
| pop_valid_o | output | 1 | One-cycle pulse after an accepted pop |
| top_o | output | WIDTH | Current top entry, 0 when empty |
| sp_o | output | $clog2(DEPTH+1) | Stack pointer |
| full_o | output | 1 | Stack full flag |
| empty_o | output | 1 | Stack empty flag |
| err_o | output | 1 | One-cycle pulse after a rejected command |

## Verification
The bench builds the stack with DEPTH 4 and WIDTH 8. With four entries, every occupancy from empty to full is reached in a few cycles. Both flag transitions and all rejection cases are therefore driven directly, including every unknown command code. With 8-bit words, the expected values for add and multiply are computed in the bench over a wide grid of operand pairs, and sums and products that wrap are checked modulo 256. The postfix example that yields 42 also fits this word size.

// File: rtl/rpn_stack_pkg.sv
package rpn_stack_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_ADD  = 3'd3,
    OP_MUL  = 3'd4
  } op_e;
endpackage

// File: rtl/rpn_stack_regs.sv
module rpn_stack_regs #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 11,
  parameter int PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [WIDTH-1:0] rdata_a_o,
  output logic [WIDTH-1:0] rdata_b_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] raddr_b;

  assign raddr_b = raddr_i + PTR_W'(1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[i] <= '0;
      else if (we_i && waddr_i == PTR_W'(i))     mem_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr_i == PTR_W'(i)) rdata_a_o = mem_q[i];
      if (raddr_b == PTR_W'(i)) rdata_b_o = mem_q[i];
    end
  end

  assert_waddr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (waddr_i < PTR_W'(DEPTH)));
endmodule

// File: rtl/rpn_stack_alu.sv
module rpn_stack_alu #(
  parameter int WIDTH = 16
) (
  input  logic             op_mul_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);
  localparam int PW = 2 * WIDTH;
  logic [PW-1:0]    prod;
  logic [WIDTH-1:0] sum;

  assign sum  = a_i + b_i;
  assign prod = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};
  // results wrap to the word width
  assign y_o  = op_mul_i ? prod[WIDTH-1:0] : sum;
endmodule

// File: rtl/rpn_stack_ctrl.sv
module rpn_stack_ctrl
  import rpn_stack_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 11,
  parameter int PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cmd_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] rd_a_i,
  input  logic [WIDTH-1:0] alu_y_i,
  output logic [PTR_W-1:0] sp_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o,
  output logic             pop_valid_o,
  output logic [WIDTH-1:0] data_o,
  output logic             we_o,
  output logic [PTR_W-1:0] waddr_o,
  output logic [WIDTH-1:0] wdata_o,
  output logic             op_mul_o
);
  localparam logic [PTR_W-1:0] SP_BOT = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] SP_AR  = PTR_W'(DEPTH - 2);

  logic [PTR_W-1:0] sp_q, sp_m1, sp_p1;
  logic             full_q, empty_q, err_q, pv_q;
  logic [WIDTH-1:0] dout_q;
  logic is_push, is_pop, is_ar, push_ok, pop_ok, ar_ok, illegal;

  assign is_push  = (cmd_i == OP_PUSH);
  assign is_pop   = (cmd_i == OP_POP);
  assign is_ar    = (cmd_i == OP_ADD) || (cmd_i == OP_MUL);
  assign push_ok  = is_push && !full_q;
  assign pop_ok   = is_pop && !empty_q;
  assign ar_ok    = is_ar && (sp_q <= SP_AR);
  assign illegal  = (cmd_i != OP_NOP) && !(push_ok || pop_ok || ar_ok);

  assign sp_m1    = sp_q - PTR_W'(1);
  assign sp_p1    = sp_q + PTR_W'(1);

  // push writes at pre-decremented sp; arithmetic overwrites second entry
  assign we_o     = push_ok || ar_ok;
  assign waddr_o  = push_ok ? sp_m1 : sp_p1;
  assign wdata_o  = push_ok ? data_i : alu_y_i;
  assign op_mul_o = (cmd_i == OP_MUL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q    <= SP_BOT;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
      pv_q    <= 1'b0;
      dout_q  <= '0;
    end else begin
      err_q <= illegal;
      pv_q  <= pop_ok;
      if (push_ok) begin
        sp_q    <= sp_m1;
        full_q  <= (sp_m1 == '0);
        empty_q <= 1'b0;
      end else if (pop_ok) begin
        sp_q    <= sp_p1;
        full_q  <= 1'b0;
        empty_q <= (sp_p1 == SP_BOT);
        dout_q  <= rd_a_i;
      end else if (ar_ok) begin
        sp_q    <= sp_p1;
        full_q  <= 1'b0;
        empty_q <= 1'b0;
      end
    end
  end

  assign sp_o        = sp_q;
  assign full_o      = full_q;
  assign empty_o     = empty_q;
  assign err_o       = err_q;
  assign pop_valid_o = pv_q;
  assign data_o      = dout_q;

  assert_flags_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_q && empty_q));
  assert_full_at_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> (sp_q == '0));
  assert_empty_at_bottom_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_q |-> (sp_q == SP_BOT));
  assert_push_predec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ok |=> (sp_q == $past(sp_q) - PTR_W'(1)));
  assert_pop_postinc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok |=> (pv_q && sp_q == $past(sp_q) + PTR_W'(1)));
  assert_reject_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal |=> (err_q && $stable(sp_q) && !pv_q));
endmodule

// File: rtl/rpn_stack.sv
module rpn_stack #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 11,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cmd_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             pop_valid_o,
  output logic [WIDTH-1:0] top_o,
  output logic [PTR_W-1:0] sp_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o
);
  logic             we, op_mul;
  logic [PTR_W-1:0] waddr, sp;
  logic [WIDTH-1:0] wdata, rd_a, rd_b, alu_y;

  rpn_stack_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk_i, .rst_ni, .cmd_i, .data_i,
    .rd_a_i(rd_a), .alu_y_i(alu_y),
    .sp_o(sp), .full_o, .empty_o, .err_o, .pop_valid_o, .data_o,
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .op_mul_o(op_mul)
  );

  rpn_stack_regs #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_regs (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(sp), .rdata_a_o(rd_a), .rdata_b_o(rd_b)
  );

  rpn_stack_alu #(.WIDTH(WIDTH)) u_alu (
    .op_mul_i(op_mul), .a_i(rd_a), .b_i(rd_b), .y_o(alu_y)
  );

  assign sp_o  = sp;
  assign top_o = empty_o ? '0 : rd_a;
endmodule

// File: tb/rpn_stack_bench.sv
`timescale 1ns/1ps
module rpn_stack_bench;
  localparam int W = 8;
  localparam int D = 4;
  localparam int PW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd = 3'd0;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  dout, top;
  logic [PW-1:0] sp;
  logic          pv, full, empty, err;
  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  rpn_stack #(.WIDTH(W), .DEPTH(D)) u_rpn_stack (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .data_i(din),
    .data_o(dout), .pop_valid_o(pv), .top_o(top), .sp_o(sp),
    .full_o(full), .empty_o(empty), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, sample at following negedge (one register stage)
  task automatic run(input int op, input int d);
    cmd = 3'(op);
    din = W'(d);
    @(negedge clk);
    cmd = 3'd0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    @(negedge clk);
    chk("R1 sp in reset", int'(sp), D);
    chk("R1 empty in reset", int'(empty), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp", int'(sp), D);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 pop_valid", int'(pv), 0);

    // R2 R3: fill stack
    for (int i = 0; i < D; i++) begin
      run(1, 10 + i);
      chk("R2 sp predec", int'(sp), D - 1 - i);
      chk("R2 top", int'(top), 10 + i);
      chk("R3 empty cleared", int'(empty), 0);
      chk("R3 full", int'(full), (i == D - 1) ? 1 : 0);
      chk("R2 no err", int'(err), 0);
    end
    // R8: push when full
    run(1, 99);
    chk("R8 err", int'(err), 1);
    chk("R8 sp held", int'(sp), 0);
    chk("R8 top held", int'(top), 10 + D - 1);
    chk("R8 full held", int'(full), 1);
    @(negedge clk);
    chk("R8 err one cycle", int'(err), 0);

    // R4 R5: drain
    for (int i = D - 1; i >= 0; i--) begin
      run(2, 0);
      chk("R4 data LIFO", int'(dout), 10 + i);
      chk("R4 pop_valid", int'(pv), 1);
      chk("R4 sp postinc", int'(sp), D - i);
      chk("R5 full cleared", int'(full), 0);
      chk("R5 empty", int'(empty), (i == 0) ? 1 : 0);
      @(negedge clk);
      chk("R4 pop_valid one cycle", int'(pv), 0);
    end
    // R9: pop when empty
    run(2, 0);
    chk("R9 err", int'(err), 1);
    chk("R9 pop_valid", int'(pv), 0);
    chk("R9 sp held", int'(sp), D);
    chk("R9 data held", int'(dout), 10);

    // R10: arithmetic with fewer than two entries
    run(3, 0);
    chk("R10 add empty err", int'(err), 1);
    chk("R10 add empty sp", int'(sp), D);
    run(1, 7);
    run(4, 0);
    chk("R10 mul one err", int'(err), 1);
    chk("R10 mul one sp", int'(sp), D - 1);
    chk("R10 mul one top", int'(top), 7);
    run(3, 0);
    chk("R10 add one err", int'(err), 1);
    chk("R10 add one top", int'(top), 7);

    // R11: nop and unknown codes
    run(0, 0);
    chk("R11 nop no err", int'(err), 0);
    chk("R11 nop sp", int'(sp), D - 1);
    for (int c = 5; c < 8; c++) begin
      run(c, 55);
      chk("R11 bad code err", int'(err), 1);
      chk("R11 bad code sp", int'(sp), D - 1);
      chk("R11 bad code top", int'(top), 7);
    end
    run(2, 0);
    chk("R11 stack intact", int'(dout), 7);

    // R12: 3 4 * 5 6 * +
    run(1, 3); run(1, 4); run(4, 0);
    chk("R12 partial 12", int'(top), 12);
    run(1, 5); run(1, 6); run(4, 0);
    chk("R12 partial 30", int'(top), 30);
    run(3, 0);
    chk("R12 result", int'(top), 42);
    chk("R12 one entry", int'(sp), D - 1);
    chk("R12 not empty", int'(empty), 0);
    run(2, 0);
    chk("R12 popped", int'(dout), 42);
    chk("R12 empty after", int'(empty), 1);

    // R6 R7: operand grid with wraparound
    for (int a = 0; a < 256; a += 15) begin
      for (int b = 0; b < 256; b += 23) begin
        run(1, a); run(1, b); run(3, 0);
        chk("R6 sum", int'(top), (a + b) % 256);
        chk("R6 sp", int'(sp), D - 1);
        run(2, 0);
        run(1, a); run(1, b); run(4, 0);
        chk("R7 product", int'(top), (a * b) % 256);
        chk("R7 sp", int'(sp), D - 1);
        run(2, 0);
        chk("R7 popped", int'(dout), (a * b) % 256);
      end
    end
    run(1, 255); run(1, 255); run(3, 0);
    chk("R6 max sum", int'(top), 254);
    run(1, 255); run(4, 0);
    chk("R7 max product", int'(top), (254 * 255) % 256);
    summary();
  end
endmodule